// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Every clock cycle an event source hands it, for each of a small set of event lanes, a count of how many times that event happened in the cycle, together with an attribute vector per lane. Software picks a lane with an 8-bit event code and narrows it with an 8-bit sub-event mask. A second copy of the lane counts, coming from a sibling logical processor, can be merged in on request.

The selected per-cycle count passes through a qualification stage before it is added to a 40-bit accumulator. That stage can compare the count against a threshold, invert the sense of that compare, count only the cycles in which the qualified condition turns true, and filter by the privilege ring the processor is running in. When the accumulator wraps and interrupts are enabled, a sticky overflow flag is set and drives an interrupt request until software clears it.

Software reaches the control word, both halves of the accumulator and the overflow status through a single-cycle register port. Reads are combinational. Writes take effect at the next clock edge.

Top module: `pmc_qual_counter`

## Requirements
- R1: After reset, the control word, the accumulator and the overflow flag read as zero, and `irq_o` is low.
- R2: Register addresses are: 0 control, 1 accumulator bits [31:0], 2 accumulator bits [39:32] (zero-extended), 3 status with the overflow flag in bit 0. The control word layout is: threshold [31:24], invert [23], enable [22], any-thread [21], interrupt enable [20], edge mode [18], ring-0 enable [17], rings-1..3 enable [16], sub-event mask [15:8], event code [7:0]. Bit 19 always reads zero.
- R3: The event code selects lane number `code` when `code` is below NUM_CODES; any larger code selects a count of zero. The lane contributes only when the mask is zero or the mask shares at least one set bit with the lane's attribute vector.
- R4: With any-thread set, the selected count is the bitwise OR of the own-thread and other-thread counts of that lane. Otherwise only the own-thread count is used.
- R5: With threshold zero and edge mode off, the accumulator adds the selected count (0..7) each cycle. The sum appears one clock after the count is presented.
- R6: With a nonzero threshold and invert clear, the accumulator adds 1 in each cycle whose selected count is greater than or equal to the threshold, and 0 otherwise.
- R7: With a nonzero threshold and invert set, the accumulator adds 1 in each cycle whose count is below the threshold. With threshold zero, the invert bit has no effect.
- R8: In edge mode the accumulator adds 1 only in a cycle where the qualified condition is true and was false the cycle before. The condition is "count nonzero" when the threshold is zero, and the threshold compare otherwise. The remembered state is false after reset, after any cycle in which enable is clear, and after any cycle the privilege filter blocked. A condition that is already true when counting is enabled therefore counts once.
- R9: At ring 0 counting requires the ring-0 enable. At rings 1, 2 and 3 it requires the rings-1..3 enable. When both enables are clear, all rings count.
- R10: With enable clear, the accumulator does not change except by software writes.
- R11: A software write to either accumulator half replaces that half in that clock. No increment is applied in that cycle.
- R12: When an increment carries out of bit 39 and interrupt enable is set, the overflow flag and `irq_o` become 1 and stay 1 until a write to address 3 with bit 0 set. A wrap with interrupt enable clear leaves the flag at 0. A wrap in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| own_cnt_i | input | NUM_CODES*CIN_W | Per-lane event counts of this logical processor, lane l at bits [l*CIN_W +: CIN_W] |
| oth_cnt_i | input | NUM_CODES*CIN_W | Per-lane event counts of the sibling logical processor |
| lane_attr_i | input | NUM_CODES*8 | Per-lane sub-event attribute vectors, lane l at bits [l*8 +: 8] |
| priv_i | input | 2 | Current privilege ring (0 to 3) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Overflow interrupt request, level, sticky |

## Verification
The qualification stage is swept over every pairing of per-cycle count (0..7), threshold (0..7) and invert bit. This separates raw accumulation from the at-or-above compare, the below compare, and the rule that invert is ignored when the threshold is zero. Lane selection is swept over in-range and out-of-range codes with masks that hit, miss or are zero. The privilege filter is swept over all four rings against all four combinations of the ring enables. Short hand-built count sequences with repeated, gapped and already-asserted conditions separate edge counting from level counting. Near-full accumulator values separate wrap with and without interrupt enable, and a clear that lands in the same cycle as a wrap.

// File: rtl/pmc_qual_pkg.sv
package pmc_qual_pkg;

   localparam int REG_W    = 32;
   localparam int ATTR_W   = 8;
   localparam int CODE_W   = 8;
   localparam int THRESH_W = 8;

   localparam logic [1:0] ADDR_CTRL   = 2'd0;
   localparam logic [1:0] ADDR_CNT_LO = 2'd1;
   localparam logic [1:0] ADDR_CNT_HI = 2'd2;
   localparam logic [1:0] ADDR_STAT   = 2'd3;

   // control word, MSB first
   typedef struct packed {
      logic [THRESH_W-1:0] thresh;
      logic                invert;
      logic                enable;
      logic                any_thr;
      logic                irq_en;
      logic                rsvd;
      logic                edge_mode;
      logic                ring0_en;
      logic                ring123_en;
      logic [ATTR_W-1:0]   umask;
      logic [CODE_W-1:0]   code;
   } pmc_ctrl_t;

   // writable bits of the control word (bit 19 held at zero)
   localparam logic [REG_W-1:0] CTRL_WMASK = 32'hFFF7_FFFF;

endpackage

// File: rtl/pmc_evt_select.sv
module pmc_evt_select
   import pmc_qual_pkg::*;
#(
   parameter int NUM_CODES = 4,
   parameter int CIN_W     = 3,
   parameter bit USE_OTHER = 1'b1
) (
   input  logic [NUM_CODES*CIN_W-1:0]  own_cnt_i,
   input  logic [NUM_CODES*CIN_W-1:0]  oth_cnt_i,
   input  logic [NUM_CODES*ATTR_W-1:0] attr_i,
   input  logic [CODE_W-1:0]           code_i,
   input  logic [ATTR_W-1:0]           umask_i,
   input  logic                        any_i,
   output logic [CIN_W-1:0]            cnt_o
);

   logic [CIN_W-1:0] lane_val [NUM_CODES];

   for (genvar l = 0; l < NUM_CODES; l++) begin : g_lane
      logic [CIN_W-1:0]  own_l;
      logic [CIN_W-1:0]  merged_l;
      logic [ATTR_W-1:0] attr_l;
      logic              match_l;

      assign own_l   = own_cnt_i[l*CIN_W +: CIN_W];
      assign attr_l  = attr_i[l*ATTR_W +: ATTR_W];
      assign match_l = (umask_i == '0) || ((attr_l & umask_i) != '0);

      if (USE_OTHER) begin : g_merge
         logic [CIN_W-1:0] oth_l;
         assign oth_l    = oth_cnt_i[l*CIN_W +: CIN_W];
         assign merged_l = any_i ? (own_l | oth_l) : own_l;
      end else begin : g_own_only
         logic unused_l;
         assign unused_l = any_i ^ (^oth_cnt_i[l*CIN_W +: CIN_W]);
         assign merged_l = own_l;
      end

      assign lane_val[l] = match_l ? merged_l : '0;
   end

   always_comb begin
      cnt_o = '0;
      for (int l = 0; l < NUM_CODES; l++) begin
         if (code_i == CODE_W'(l)) cnt_o = lane_val[l];
      end
   end

endmodule

// File: rtl/pmc_qual_engine.sv
module pmc_qual_engine
   import pmc_qual_pkg::*;
#(
   parameter int CIN_W = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [CIN_W-1:0]    cnt_i,
   input  logic [THRESH_W-1:0] thresh_i,
   input  logic                invert_i,
   input  logic                edge_i,
   input  logic                enable_i,
   input  logic                ring0_en_i,
   input  logic                ring123_en_i,
   input  logic [1:0]          priv_i,
   output logic [CIN_W-1:0]    amt_o
);

   logic [THRESH_W-1:0] cnt_ext;
   logic thr_on, at_or_above, cond_raw, cond, ring_ok, gate, prev_q, both_off;

   assign cnt_ext     = THRESH_W'(cnt_i);
   assign thr_on      = (thresh_i != '0);
   assign at_or_above = (cnt_ext >= thresh_i);
   assign cond_raw    = thr_on ? (invert_i ? !at_or_above : at_or_above)
                               : (cnt_i != '0);

   assign both_off = !ring0_en_i && !ring123_en_i;
   assign ring_ok  = (priv_i == 2'd0) ? (ring0_en_i || both_off)
                                      : (ring123_en_i || both_off);
   assign gate     = enable_i && ring_ok;
   assign cond     = cond_raw && gate;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        prev_q <= 1'b0;
      else if (!enable_i) prev_q <= 1'b0;
      else                prev_q <= cond;
   end

   always_comb begin
      if (!gate)       amt_o = '0;
      else if (edge_i) amt_o = (cond && !prev_q) ? CIN_W'(1) : '0;
      else if (thr_on) amt_o = cond ? CIN_W'(1) : '0;
      else             amt_o = cnt_i;
   end

   assert_unit_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i || thr_on) |-> (amt_o <= CIN_W'(1)));

   assert_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |-> (amt_o == '0));

   assert_edge_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_i && enable_i && amt_o != '0) |=> (!(edge_i && enable_i) || amt_o == '0));

   assert_ring_filter_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (priv_i != 2'd0 && ring0_en_i && !ring123_en_i) |-> (amt_o == '0));

endmodule

// File: rtl/pmc_cnt_core.sv
module pmc_cnt_core
   import pmc_qual_pkg::*;
#(
   parameter int CNT_W = 40,
   parameter int CIN_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CIN_W-1:0] amt_i,
   input  logic             wr_lo_i,
   input  logic             wr_hi_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             irq_en_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);

   localparam int HI_W = CNT_W - REG_W;

   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] cnt_q, cnt_nxt;
   logic             carry, ovf_q, wr_any;

   assign sum    = {1'b0, cnt_q} + (CNT_W+1)'(amt_i);
   assign carry  = sum[CNT_W];
   assign wr_any = wr_lo_i || wr_hi_i;

   always_comb begin
      cnt_nxt = sum[CNT_W-1:0];
      if (wr_lo_i)      cnt_nxt = {cnt_q[CNT_W-1:REG_W], wr_data_i};
      else if (wr_hi_i) cnt_nxt = {wr_data_i[HI_W-1:0], cnt_q[REG_W-1:0]};
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         if (carry && irq_en_i && !wr_any) ovf_q <= 1'b1;
         else if (clr_i)                   ovf_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_any && amt_i == '0) |=> $stable(cnt_o));

   assert_write_lo_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_lo_i |=> (cnt_o[REG_W-1:0] == $past(wr_data_i)));

   assert_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !clr_i) |=> ovf_o);

   assert_no_spurious_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovf_o && !irq_en_i) |=> !ovf_o);

endmodule

// File: rtl/pmc_qual_counter.sv
module pmc_qual_counter
   import pmc_qual_pkg::*;
#(
   parameter int NUM_CODES = 4,
   parameter int CIN_W     = 3,
   parameter int CNT_W     = 40,
   parameter bit USE_OTHER = 1'b1
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic [NUM_CODES*CIN_W-1:0]  own_cnt_i,
   input  logic [NUM_CODES*CIN_W-1:0]  oth_cnt_i,
   input  logic [NUM_CODES*ATTR_W-1:0] lane_attr_i,
   input  logic [1:0]                  priv_i,
   input  logic                        wr_en_i,
   input  logic [1:0]                  wr_addr_i,
   input  logic [REG_W-1:0]            wr_data_i,
   input  logic [1:0]                  rd_addr_i,
   output logic [REG_W-1:0]            rd_data_o,
   output logic                        irq_o
);

   localparam int HI_W = CNT_W - REG_W;

   if (CNT_W <= REG_W || CNT_W >= 2*REG_W) begin : g_bad_cnt_w
      $error("CNT_W must lie strictly between REG_W and 2*REG_W");
   end
   if (CIN_W < 1 || CIN_W > THRESH_W) begin : g_bad_cin_w
      $error("CIN_W must be 1..THRESH_W");
   end
   if (NUM_CODES < 1 || NUM_CODES > (1 << CODE_W)) begin : g_bad_codes
      $error("NUM_CODES must be 1..256");
   end

   pmc_ctrl_t        ctrl_q;
   logic [CIN_W-1:0] sel_cnt, amt;
   logic [CNT_W-1:0] cnt;
   logic             ovf, wr_ctrl, wr_lo, wr_hi, clr;

   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
   assign wr_lo   = wr_en_i && (wr_addr_i == ADDR_CNT_LO);
   assign wr_hi   = wr_en_i && (wr_addr_i == ADDR_CNT_HI);
   assign clr     = wr_en_i && (wr_addr_i == ADDR_STAT) && wr_data_i[0];

   always_ff @(posedge clk_i) begin
      if (!rst_ni)      ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= pmc_ctrl_t'(wr_data_i & CTRL_WMASK);
   end

   pmc_evt_select #(
      .NUM_CODES (NUM_CODES),
      .CIN_W     (CIN_W),
      .USE_OTHER (USE_OTHER)
   ) u_sel (
      .own_cnt_i (own_cnt_i),
      .oth_cnt_i (oth_cnt_i),
      .attr_i    (lane_attr_i),
      .code_i    (ctrl_q.code),
      .umask_i   (ctrl_q.umask),
      .any_i     (ctrl_q.any_thr),
      .cnt_o     (sel_cnt)
   );

   pmc_qual_engine #(
      .CIN_W (CIN_W)
   ) u_qual (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .cnt_i        (sel_cnt),
      .thresh_i     (ctrl_q.thresh),
      .invert_i     (ctrl_q.invert),
      .edge_i       (ctrl_q.edge_mode),
      .enable_i     (ctrl_q.enable),
      .ring0_en_i   (ctrl_q.ring0_en),
      .ring123_en_i (ctrl_q.ring123_en),
      .priv_i       (priv_i),
      .amt_o        (amt)
   );

   pmc_cnt_core #(
      .CNT_W (CNT_W),
      .CIN_W (CIN_W)
   ) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .amt_i     (amt),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wr_data_i (wr_data_i),
      .irq_en_i  (ctrl_q.irq_en),
      .clr_i     (clr),
      .cnt_o     (cnt),
      .ovf_o     (ovf)
   );

   always_comb begin
      unique case (rd_addr_i)
         ADDR_CTRL:   rd_data_o = ctrl_q;
         ADDR_CNT_LO: rd_data_o = cnt[REG_W-1:0];
         ADDR_CNT_HI: rd_data_o = {{(REG_W-HI_W){1'b0}}, cnt[CNT_W-1:REG_W]};
         default:     rd_data_o = {{(REG_W-1){1'b0}}, ovf};
      endcase
   end

   assign irq_o = ovf;

   assert_irq_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr && !ctrl_q.irq_en) |=> !irq_o);

endmodule

// File: tb/tb_pmc_qual_counter.sv
module tb_pmc_qual_counter;

   localparam int NC = 4;
   localparam int CW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NC*CW-1:0]  own_cnt, oth_cnt;
   logic [NC*8-1:0]   attr;
   logic [1:0]        priv = 2'd0;
   logic              wr_en = 1'b0;
   logic [1:0]        wr_addr = 2'd0;
   logic [31:0]       wr_data = '0;
   logic [1:0]        rd_addr = 2'd0;
   logic [31:0]       rd_data;
   logic              irq;

   logic [CW-1:0] own_v [NC];
   logic [CW-1:0] oth_v [NC];
   logic [7:0]    attr_v [NC];

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   always_comb begin
      for (int l = 0; l < NC; l++) begin
         own_cnt[l*CW +: CW] = own_v[l];
         oth_cnt[l*CW +: CW] = oth_v[l];
         attr[l*8 +: 8]      = attr_v[l];
      end
   end

   pmc_qual_counter dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .own_cnt_i   (own_cnt),
      .oth_cnt_i   (oth_cnt),
      .lane_attr_i (attr),
      .priv_i      (priv),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .rd_addr_i   (rd_addr),
      .rd_data_o   (rd_data),
      .irq_o       (irq)
   );

   function automatic logic [31:0] mk(int thr, bit inv, bit en, bit anyt, bit ie,
                                      bit edg, bit os, bit usr, int um, int code);
      return {thr[7:0], inv, en, anyt, ie, 1'b0, edg, os, usr, um[7:0], code[7:0]};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   task automatic rdcnt(output logic [63:0] v);
      logic [31:0] lo, hi;
      rd(2'd1, lo); rd(2'd2, hi);
      v = {hi, lo};
   endtask

   task automatic clr_events();
      for (int l = 0; l < NC; l++) begin own_v[l] = '0; oth_v[l] = '0; attr_v[l] = '0; end
   endtask

   task automatic zero_cnt();
      wr(2'd2, 32'h0); wr(2'd1, 32'h0);
   endtask

   // configure with events already applied, clear counter, run n cycles
   task automatic measure(input logic [31:0] ctl, input int n, output logic [63:0] v);
      wr(2'd0, ctl);
      zero_cnt();
      repeat (n) @(negedge clk);
      rdcnt(v);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic [31:0] d;
      clr_events();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd0, d); chk("R1 ctrl", d, 0);
      rdcnt(v);    chk("R1 counter", v, 0);
      rd(2'd3, d); chk("R1 status", d, 0);
      chk("R1 irq", irq, 0);

      // R2 layout, reserved bit 19
      wr(2'd0, 32'hFFBF_FFFF);
      rd(2'd0, d); chk("R2 ctrl readback", d, 32'hFFB7_FFFF);
      wr(2'd0, 32'h0);
      wr(2'd2, 32'hFFFF_FFA5);
      rd(2'd2, d); chk("R2 high half width", d, 32'hA5);

      // R5 R6 R7 sweep of count x threshold x invert
      for (int thr = 0; thr < 8; thr++)
         for (int inv = 0; inv < 2; inv++)
            for (int n = 0; n < 8; n++) begin
               int per;
               clr_events();
               own_v[1] = CW'(n);
               measure(mk(thr, inv[0], 1, 0, 0, 0, 0, 0, 0, 1), 5, v);
               if (thr == 0)     per = n;
               else if (inv == 1) per = (n < thr) ? 1 : 0;
               else              per = (n >= thr) ? 1 : 0;
               chk(thr == 0 ? "R5 raw add" : (inv == 1 ? "R7 inverted compare" : "R6 threshold compare"),
                   v, 64'(5 * per));
            end

      // R3 lane selection and mask
      for (int code = 0; code < 6; code++)
         for (int k = 0; k < 3; k++) begin
            int um, per;
            um = (k == 0) ? 0 : ((k == 1) ? 8'h01 : 8'h10);
            clr_events();
            for (int l = 0; l < NC; l++) begin own_v[l] = CW'(l + 1); attr_v[l] = 8'(1 << l); end
            measure(mk(0, 0, 1, 0, 0, 0, 0, 0, um, code), 3, v);
            per = 0;
            if (code < NC && (um == 0 || ((1 << code) & um) != 0)) per = code + 1;
            chk("R3 select", v, 64'(3 * per));
         end

      // R4 any-thread merge
      clr_events(); own_v[2] = 3'b101; oth_v[2] = 3'b010;
      measure(mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 2), 2, v); chk("R4 any or", v, 14);
      measure(mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 2), 2, v); chk("R4 own only", v, 10);
      own_v[2] = 3'd3; oth_v[2] = 3'd5;
      measure(mk(0, 0, 1, 1, 0, 0, 0, 0, 0, 2), 2, v); chk("R4 any overlap", v, 14);

      // R9 privilege sweep
      for (int os = 0; os < 2; os++)
         for (int us = 0; us < 2; us++)
            for (int ring = 0; ring < 4; ring++) begin
               int ok;
               clr_events(); own_v[0] = 3'd2; priv = 2'(ring);
               measure(mk(0, 0, 1, 0, 0, 0, os[0], us[0], 0, 0), 3, v);
               if (os == 0 && us == 0) ok = 1;
               else ok = (ring == 0) ? os : us;
               chk("R9 ring filter", v, 64'(6 * ok));
            end
      priv = 2'd0;

      // R8 edge, threshold zero
      begin
         int seq_a [8] = '{3, 3, 0, 1, 2, 0, 0, 5};
         int seq_b [8] = '{1, 2, 3, 1, 4, 4, 0, 2};
         clr_events();
         wr(2'd0, 32'h0);
         wr(2'd0, mk(0, 0, 1, 0, 0, 1, 0, 0, 0, 0));
         zero_cnt();
         for (int i = 0; i < 8; i++) begin own_v[0] = CW'(seq_a[i]); @(negedge clk); end
         own_v[0] = '0;
         rdcnt(v); chk("R8 edge nonzero count", v, 3);
         wr(2'd0, 32'h0);
         wr(2'd0, mk(2, 0, 1, 0, 0, 1, 0, 0, 0, 0));
         zero_cnt();
         for (int i = 0; i < 8; i++) begin own_v[0] = CW'(seq_b[i]); @(negedge clk); end
         own_v[0] = '0;
         rdcnt(v); chk("R8 edge threshold", v, 3);
      end
      // R8 already-true at enable, and re-arm by disabling
      wr(2'd0, 32'h0);
      own_v[0] = 3'd4;
      zero_cnt();
      wr(2'd0, mk(0, 0, 1, 0, 0, 1, 0, 0, 0, 0));
      repeat (4) @(negedge clk);
      rdcnt(v); chk("R8 true at enable", v, 1);
      wr(2'd0, mk(0, 0, 0, 0, 0, 1, 0, 0, 0, 0));
      wr(2'd0, mk(0, 0, 1, 0, 0, 1, 0, 0, 0, 0));
      repeat (3) @(negedge clk);
      rdcnt(v); chk("R8 re-arm after disable", v, 2);

      // R10 disabled
      clr_events(); own_v[0] = 3'd5;
      measure(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 4, v); chk("R10 disabled", v, 0);
      measure(mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 0), 4, v); chk("R10 disabled inv", v, 0);

      // R11 write priority
      own_v[0] = 3'd7;
      wr(2'd0, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd1, 32'd100);
      rdcnt(v); chk("R11 write wins", v[31:0], 100);
      @(negedge clk);
      rdcnt(v); chk("R11 then counts", v[31:0], 107);

      // R12 overflow
      clr_events();
      wr(2'd0, mk(0, 0, 1, 0, 1, 0, 0, 0, 0, 0));
      wr(2'd2, 32'hFF); wr(2'd1, 32'hFFFF_FFFE);
      rd(2'd3, d); chk("R12 no flag before wrap", d, 0);
      own_v[0] = 3'd3; @(negedge clk); own_v[0] = '0;
      rdcnt(v); chk("R12 wrap value", v, 1);
      rd(2'd3, d); chk("R12 flag set", d, 1);
      chk("R12 irq set", irq, 1);
      wr(2'd3, 32'h0);
      rd(2'd3, d); chk("R12 sticky", d, 1);
      wr(2'd3, 32'h1);
      rd(2'd3, d); chk("R12 cleared", d, 0);
      chk("R12 irq cleared", irq, 0);
      wr(2'd0, mk(0, 0, 1, 0, 0, 0, 0, 0, 0, 0));
      wr(2'd2, 32'hFF); wr(2'd1, 32'hFFFF_FFFE);
      own_v[0] = 3'd3; @(negedge clk); own_v[0] = '0;
      rd(2'd3, d); chk("R12 no irq_en no flag", d, 0);
      wr(2'd0, mk(0, 0, 1, 0, 1, 0, 0, 0, 0, 0));
      wr(2'd2, 32'hFF); wr(2'd1, 32'hFFFF_FFFE);
      own_v[0] = 3'd3;
      wr(2'd3, 32'h1);
      own_v[0] = '0;
      rd(2'd3, d); chk("R12 set wins over clear", d, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule